// File: doc/BRIEF.md
# First-Order Noise Shaper with Segmented DAC Decoder

This block sits between one channel's up-sampled audio datapath and the digital controls of a segmented current-steering DAC. Each accepted 22-bit two's-complement sample is shortened to a 15-bit two's-complement word. The low bits that would be dropped are not discarded. The remainder left by the previous truncation is added to the next sample before it is cut, so the quantization error is pushed toward high frequencies.

The shaped word waits in a holding register until a shared strobe at four times the audio rate. On that strobe it is copied into the DAC output registers. Because every channel sees the same strobe, all channels change together. The registered outputs split the word into three controls: a current-direction bit, a 32-line thermometer code for the coarse current sources, and a 9-bit binary select for the 512-step fine divider. All three are registered, so no mix of old and new fields is ever visible.

Top module: `ns_seg_dac`

## Requirements
- R1: While reset is held, and on the first cycle after it, the direction bit, all 32 thermometer lines, the fine select and the internal error remainder are zero.
- R2: A sample is taken only on a clock edge with `smp_vld` high. The shaped word is floor((sample + e) / 128), where e is the stored remainder. The new remainder is (sample + e) minus 128 times that word, which lies in the range 0 to 127.
- R3: The remainder from one accepted sample is added to the next accepted sample, and only to that one. A constant input of 64 therefore gives shaped words that alternate 0, 1, 0, 1, and so on.
- R4: If sample + e exceeds what the 15-bit word can hold, the word saturates to 16383 and the remainder is cleared. The error is never negative, so the negative limit cannot be exceeded.
- R5: The output fields change only on an edge with `lat_stb` high. They then take the shaped word held before that edge. A sample accepted on the same edge appears at the next strobe.
- R6: `dac_neg` equals bit 14 of the latched word, which is its sign bit.
- R7: `dac_therm` has lines 0 to v-1 high and all other lines low, where v is the 5-bit value in bits 13:9 of the latched word. Line 31 is therefore never driven high.
- R8: `dac_fine` equals bits 8:0 of the latched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Accept `smp_in` on this edge |
| smp_in | input | 22 | Two's-complement input sample |
| lat_stb | input | 1 | Four-times-rate DAC latch strobe |
| dac_neg | output | 1 | Current-direction control (word sign) |
| dac_therm | output | 32 | Coarse-source thermometer enables |
| dac_fine | output | 9 | Fine divider select |

## Verification
A run of small positive values checks that the remainder carries forward. Two equal inputs of 100 give 0 and then 1, a result that plain truncation cannot produce. A constant 64 must alternate between 0 and 1. A series of negative values, including the most negative input, confirms floor truncation and the sign and direction mapping. Coarse values spread across the whole range separate the thermometer decoding from the fine field. The largest positive input with a non-zero remainder must saturate. Three further cases cover the latch timing: a sample accepted with no strobe, a strobe with no new sample, and a sample and strobe on the same edge.

// File: rtl/ns_seg_dac.sv
module ns_seg_dac #(
  parameter int IN_W     = 22,
  parameter int OUT_W    = 15,
  parameter int COARSE_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic [IN_W-1:0]            smp_in,
  input  logic                       lat_stb,
  output logic                       dac_neg,
  output logic [(1<<COARSE_W)-1:0]   dac_therm,
  output logic [OUT_W-COARSE_W-2:0]  dac_fine
);
  localparam int SH     = IN_W - OUT_W;
  localparam int FINE_W = OUT_W - COARSE_W - 1;
  localparam int THERM_N = 1 << COARSE_W;

  logic [SH-1:0]    err_q;
  logic [OUT_W-1:0] word_q;
  logic [IN_W:0]    sum;
  logic             ovf;
  logic [OUT_W-1:0] word_d;
  logic [SH-1:0]    err_d;
  logic [THERM_N-1:0] therm_d;
  logic [COARSE_W-1:0] coarse;

  assign sum    = {smp_in[IN_W-1], smp_in} + {{(IN_W+1-SH){1'b0}}, err_q};
  assign ovf    = sum[IN_W] != sum[IN_W-1];
  assign word_d = ovf ? (sum[IN_W] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}})
                      : sum[IN_W-1:SH];
  assign err_d  = ovf ? '0 : sum[SH-1:0];
  assign coarse = word_q[OUT_W-2 -: COARSE_W];

  for (genvar i = 0; i < THERM_N; i++) begin : g_therm
    assign therm_d[i] = coarse > COARSE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      word_q <= '0;
    end else if (smp_vld) begin
      err_q  <= err_d;
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_neg   <= 1'b0;
      dac_therm <= '0;
      dac_fine  <= '0;
    end else if (lat_stb) begin
      dac_neg   <= word_q[OUT_W-1];
      dac_therm <= therm_d;
      dac_fine  <= word_q[FINE_W-1:0];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (err_q == '0 && !dac_neg && dac_therm == '0 && dac_fine == '0));

  // R4
  sat_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && smp_in == {1'b0, {(IN_W-1){1'b1}}} && err_q != '0)
      |=> (word_q == {1'b0, {(OUT_W-1){1'b1}}} && err_q == '0));

  // R5
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_stb |=> $stable({dac_neg, dac_therm, dac_fine}));

  // R2
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(word_q) && $stable(err_q)));

  // R7
  therm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_stb |=> $countones(dac_therm) == int'($past(coarse)));

  // R7
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dac_therm & (dac_therm + 1'b1)) == '0) && !dac_therm[THERM_N-1]);

  // R6
  dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lat_stb |=> dac_neg == $past(word_q[OUT_W-1]));
endmodule

// File: tb/ns_seg_dac_tb.sv
module ns_seg_dac_tb;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        smp_vld = 0;
  logic [21:0] smp_in = '0;
  logic        lat_stb = 0;
  logic        dac_neg;
  logic [31:0] dac_therm;
  logic [8:0]  dac_fine;

  int checks = 0;
  int errors = 0;
  int err_m  = 0;
  int word_m = 0;
  int exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  ns_seg_dac u_dut (.*);

  function automatic logic [41:0] pack(input int w);
    logic [14:0] wd;
    logic [31:0] th;
    wd = w[14:0];
    th = (32'd1 << wd[13:9]) - 32'd1;
    return {wd[14], th, wd[8:0]};
  endfunction

  task automatic check(input string tag, input int w);
    logic [41:0] act, exp;
    act = {dac_neg, dac_therm, dac_fine};
    exp = pack(w);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input int x);
    int s, q;
    s = x + err_m;
    q = s >>> 7;
    if (q > 16383) begin
      q = 16383;
      err_m = 0;
    end else begin
      err_m = s - q * 128;
    end
    word_m = q;
  endtask

  task automatic send(input int x, input string tag);
    @(negedge clk);
    smp_vld = 1; smp_in = x[21:0];
    model(x);
    @(negedge clk);
    smp_vld = 0; lat_stb = 1;
    exp_q.push_back(word_m); tag_q.push_back(tag);
    @(negedge clk);
    lat_stb = 0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (rst_n && lat_stb) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected strobe actual=%h expected=none", {dac_neg, dac_therm, dac_fine});
        end else begin
          check(tag_q.pop_front(), exp_q.pop_front());
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 0);
    send(100, "R2 small");
    send(100, "R3 carry");
    send(-1, "R2 neg small");
    for (int i = 0; i < 4; i++) send(64, "R3 alternate");
    send(-200000, "R6 negative");
    send(-2097152, "R6 min");
    send(1000000, "R7 mid coarse");
    send(1900000, "R7 high coarse");
    send(511 * 128, "R8 fine max");
    send(300, "R4 prime err");
    send(2097151, "R4 saturate");
    send(0, "R4 err cleared");
    // R5: sample with no strobe leaves outputs unchanged
    @(negedge clk);
    smp_vld = 1; smp_in = 22'd700000; model(700000);
    @(negedge clk);
    smp_vld = 0;
    check("R5 no strobe", 0);
    // R5: strobe alone latches the held word
    lat_stb = 1; exp_q.push_back(word_m); tag_q.push_back("R5 strobe only");
    @(negedge clk);
    lat_stb = 0;
    // R5: same-edge sample and strobe latches old word
    @(negedge clk);
    smp_vld = 1; lat_stb = 1; smp_in = 22'h200000;
    exp_q.push_back(word_m); tag_q.push_back("R5 same edge old");
    model(-2097152);
    @(negedge clk);
    smp_vld = 0; lat_stb = 1;
    exp_q.push_back(word_m); tag_q.push_back("R5 same edge next");
    @(negedge clk);
    lat_stb = 0;
    // R1: reset mid-run clears remainder and outputs
    send(50, "R1 pre reset");
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    err_m = 0; word_m = 0;
    @(negedge clk);
    check("R1 re-reset", 0);
    send(100, "R1 err cleared");
    send(100, "R3 after reset");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule